// File: doc/BRIEF.md
# Reloadable Countdown Event Timer

This block is a countdown timer with a 64-bit counter and a small memory-mapped register set. Software writes a load value as two 32-bit words, then turns the timer on through a control register. From then on the counter steps down by one on each cycle where the tick-enable input is high. When the counter steps down from zero, the timer raises a pending-event flag. A level interrupt output presents that flag whenever the interrupt-unmask control bit is set.

There are two run modes, and one control bit chooses between them. In repeating mode the counter reloads from the load value after each event, so a load of N-1 gives one event every N ticks. In single mode the counter stops at zero after the first event. It stays there until software turns the enable bit off and back on. The control register can sit at either of two offsets, and a parameter picks which one. The pending flag is cleared by writing a one to bit 0 of the status register. The register bus and the counter share one clock. The tick input marks the cycles on which the counter advances.

Top module: `evt_timer`

## Requirements
- R1: After reset the irq output is 0, and the load-low, load-high, control and status registers all read as 0.
- R2: The load-low word sits at offset 0x00 and the load-high word at offset 0x04. Each reads back the last value written to it, and together they form the 64-bit load value {high, low}.
- R3: The control register is at offset 0x10 when parameter CTRL_ALT is 0 and at 0x1c when it is 1. Only bits [2:0] are stored: bit 0 = enable, bit 1 = single mode, bit 2 = interrupt unmask. Every offset that is not mapped reads as 0.
- R4: In repeating mode (bit 1 = 0) with load value L and tick_en held at 1, the first event reaches the irq output L+2 cycles after the edge that captures the enabling control write. Each later event follows L+1 cycles after the one before it.
- R5: In single mode (bit 1 = 1) there is exactly one event per enable, and the counter holds at zero after it. Writing enable to 0 and then back to 1 starts a new countdown from the load value.
- R6: irq equals the pending flag ANDed with control bit 2. When bit 2 is 0 the flag still sets and reads back in bit 0 of the status register at offset 0x18.
- R7: Writing a value with bit 0 = 1 to offset 0x18 clears the pending flag. Writing a value with bit 0 = 0 leaves the flag unchanged.
- R8: If a clear write and a new event happen in the same cycle, the pending flag stays set.
- R9: Writing the load registers while the timer runs does not change the countdown in progress. The next reload uses the new value.
- R10: Writing 0 to the control register stops the counter, and no event occurs while enable is 0. A rising edge of the enable bit reloads the counter from the full load value.
- R11: The counter moves only on cycles where tick_en is 1. Each cycle with tick_en low while the timer runs delays the next event by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the register bus and the counter |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Counter advance enable, one tick per high cycle |
| bus_sel | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Level interrupt: pending flag AND unmask bit |

## Verification
The periodic tests use a short load value, so event spacing and the reload count can be told apart down to a single cycle. A load-register write in the middle of a period separates "reload uses the current value" from "the count in progress restarts". A pause on the tick input separates gating by tick_en from counting plain clock cycles. In single mode the bench watches for a missing second event, and it checks that a re-enable starts a new countdown. Clear writes are placed on the exact edge of an event to show that the set wins. A masked run shows the flag and the interrupt pin behaving separately.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam logic [7:0] OFS_LOAD_LO  = 8'h00;
    localparam logic [7:0] OFS_LOAD_HI  = 8'h04;
    localparam logic [7:0] OFS_CTRL_STD = 8'h10;
    localparam logic [7:0] OFS_STATUS   = 8'h18;
    localparam logic [7:0] OFS_CTRL_ALT = 8'h1c;

    typedef struct packed {
        logic unmask;
        logic single;
        logic enable;
    } ctrl_t;

    function automatic logic [7:0] ctrl_offset(input bit alt);
        return alt ? OFS_CTRL_ALT : OFS_CTRL_STD;
    endfunction

endpackage

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
    import evt_timer_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter bit CTRL_ALT = 1'b0,
    localparam int CNT_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              flag,
    output logic [CNT_W-1:0]  load_val,
    output ctrl_t             ctrl,
    output logic              clr_req,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(OFS_LOAD_LO);
    localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(OFS_LOAD_HI);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ctrl_offset(CTRL_ALT));
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);

    typedef struct packed {
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
        ctrl_t             ctrl;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr;

    always_comb begin
        r_d     = r_q;
        wr      = bus_sel && bus_write;
        clr_req = 1'b0;
        if (wr) begin
            if (bus_addr == A_LO)   r_d.lo   = bus_wdata;
            if (bus_addr == A_HI)   r_d.hi   = bus_wdata;
            if (bus_addr == A_CTRL) r_d.ctrl = ctrl_t'(bus_wdata[2:0]);
            if (bus_addr == A_STAT) clr_req  = bus_wdata[0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_LO)        bus_rdata = r_q.lo;
        else if (bus_addr == A_HI)   bus_rdata = r_q.hi;
        else if (bus_addr == A_CTRL) bus_rdata = DATA_W'(r_q.ctrl);
        else if (bus_addr == A_STAT) bus_rdata = DATA_W'(flag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign load_val = {r_q.hi, r_q.lo};
    assign ctrl     = r_q.ctrl;

endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core
    import evt_timer_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             done,
    output logic             event_p
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             en_prev;
        logic             done;
    } core_t;

    core_t c_d, c_q;

    always_comb begin
        c_d         = c_q;
        event_p     = 1'b0;
        c_d.en_prev = ctrl.enable;
        if (!ctrl.enable) begin
            c_d.done = 1'b0;
        end else if (!c_q.en_prev) begin
            // enable rising edge: start a fresh countdown
            c_d.count = load_val;
            c_d.done  = 1'b0;
        end else if (tick_en && !c_q.done) begin
            if (c_q.count == '0) begin
                event_p = 1'b1;
                if (ctrl.single) c_d.done  = 1'b1;
                else             c_d.count = load_val;
            end else begin
                c_d.count = c_q.count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count = c_q.count;
    assign done  = c_q.done;

endmodule

// File: rtl/evt_timer_irq.sv
module evt_timer_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic event_p,
    input  logic clr_req,
    input  logic unmask,
    output logic flag,
    output logic irq
);

    typedef struct packed {
        logic pend;
    } irq_t;

    irq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        // a new event outranks a clear in the same cycle
        s_d.pend = event_p || (s_q.pend && !clr_req);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag = s_q.pend;
    assign irq  = s_q.pend && unmask;

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter bit CTRL_ALT = 1'b0,
    localparam int CNT_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] count;
    ctrl_t            ctrl;
    logic             clr_req;
    logic             flag;
    logic             done;
    logic             event_p;

    evt_timer_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CTRL_ALT (CTRL_ALT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flag      (flag),
        .load_val  (load_val),
        .ctrl      (ctrl),
        .clr_req   (clr_req),
        .bus_rdata (bus_rdata)
    );

    evt_timer_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .ctrl     (ctrl),
        .load_val (load_val),
        .count    (count),
        .done     (done),
        .event_p  (event_p)
    );

    evt_timer_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .event_p (event_p),
        .clr_req (clr_req),
        .unmask  (ctrl.unmask),
        .flag    (flag),
        .irq     (irq)
    );

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic [2:0]       ctrl_bits,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] load_val,
    input logic             event_p,
    input logic             clr_req,
    input logic             flag,
    input logic             done
);

    logic en, single;
    assign en     = ctrl_bits[0];
    assign single = ctrl_bits[1];

    assert_event_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        event_p |=> flag);

    assert_clear_drops_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !event_p) |=> !flag);

    assert_free_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (event_p && !single) |=> (count == $past(load_val)));

    assert_single_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && en) |=> $stable(count));

    assert_no_tick_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !tick_en) |=> $stable(count));

    assert_idle_no_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !event_p);

endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .ctrl_bits (ctrl),
    .count     (count),
    .load_val  (load_val),
    .event_p   (event_p),
    .clr_req   (clr_req),
    .flag      (flag),
    .done      (done)
);

// File: tb/tb_evt_timer.sv
module tb_evt_timer;

    localparam int T_NS = 20;
    localparam logic [7:0] A_LO = 8'h00, A_HI = 8'h04, A_CTRL = 8'h10,
                           A_STAT = 8'h18, A_ALT = 8'h1c;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int exp_q[$];
    logic irq_prev = 1'b0;
    bit finished = 1'b0;

    always #(T_NS/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    evt_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_sel(bus_sel), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // monitor: every rising irq edge must match the next expected cycle
    always @(negedge clk) begin
        if (rst_n && irq && !irq_prev) begin
            if (exp_q.size() == 0) chk(1'b0, "R4/R5 unexpected irq", cyc, -1);
            else begin
                int e;
                e = exp_q.pop_front();
                chk(cyc == e, "R4 irq rise cycle", cyc, e);
            end
        end
        irq_prev <= irq;
    end

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, output int cap);
        cap = cyc + 1;
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_cyc(input int e);
        while (cyc < e) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_at(input int e);
        int c;
        wait_cyc(e);
        bus_wr(A_STAT, 32'h1, c);
    endtask

    initial begin
        #(T_NS * 100000);
        chk(1'b0, "watchdog", cyc, -1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int k, c;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk(irq == 1'b0, "R1 irq", irq, 0);
        bus_rd(A_LO, rd);   chk(rd == 0, "R1 load lo", rd, 0);
        bus_rd(A_HI, rd);   chk(rd == 0, "R1 load hi", rd, 0);
        bus_rd(A_CTRL, rd); chk(rd == 0, "R1 ctrl", rd, 0);
        bus_rd(A_STAT, rd); chk(rd == 0, "R1 status", rd, 0);

        // R2 load word readback
        bus_wr(A_LO, 32'hDEAD_BEEF, c);
        bus_wr(A_HI, 32'h1234_5678, c);
        bus_rd(A_LO, rd); chk(rd == 32'hDEAD_BEEF, "R2 lo readback", rd, 32'hDEAD_BEEF);
        bus_rd(A_HI, rd); chk(rd == 32'h1234_5678, "R2 hi readback", rd, 32'h1234_5678);

        // R3 control offset, stored bits, unmapped offsets
        bus_wr(A_CTRL, 32'hFFFF_FFF6, c);
        bus_rd(A_CTRL, rd); chk(rd == 32'h6, "R3 ctrl bits", rd, 6);
        bus_rd(A_ALT, rd);  chk(rd == 0, "R3 alt offset unmapped", rd, 0);
        bus_rd(8'h08, rd);  chk(rd == 0, "R3 unmapped 0x08", rd, 0);
        bus_wr(A_CTRL, 32'h0, c);
        bus_wr(A_HI, 32'h0, c);

        // R4 + R9: repeating mode, load 4 -> period 5; load changed mid-run
        bus_wr(A_LO, 32'd4, c);
        bus_wr(A_CTRL, 32'h5, k);
        exp_q.push_back(k + 6);
        exp_q.push_back(k + 11);
        exp_q.push_back(k + 21);
        clear_at(k + 6);
        bus_wr(A_LO, 32'd9, c);               // R9 write while running
        clear_at(k + 11);
        clear_at(k + 21);
        chk(exp_q.size() == 0, "R9 reload uses new value", exp_q.size(), 0);

        // R10: stop, no events, then restart from load
        bus_wr(A_CTRL, 32'h0, c);
        idle(30);
        chk(exp_q.size() == 0, "R10 queue", exp_q.size(), 0);
        bus_rd(A_STAT, rd); chk(rd == 0, "R10 no event while off", rd, 0);
        bus_wr(A_LO, 32'd4, c);
        bus_wr(A_CTRL, 32'h5, k);
        exp_q.push_back(k + 6);
        clear_at(k + 6);
        bus_wr(A_CTRL, 32'h0, c);
        chk(exp_q.size() == 0, "R10 restart event", exp_q.size(), 0);

        // R5: single mode, load 2
        bus_wr(A_LO, 32'd2, c);
        bus_wr(A_CTRL, 32'h7, k);
        exp_q.push_back(k + 4);
        clear_at(k + 4);
        idle(20);
        bus_rd(A_STAT, rd); chk(rd == 0, "R5 no second event", rd, 0);
        chk(exp_q.size() == 0, "R5 single event seen", exp_q.size(), 0);
        bus_wr(A_CTRL, 32'h0, c);
        bus_wr(A_CTRL, 32'h7, k);
        exp_q.push_back(k + 4);
        clear_at(k + 4);
        bus_wr(A_CTRL, 32'h0, c);
        chk(exp_q.size() == 0, "R5 re-enable restarts", exp_q.size(), 0);

        // R7 + R8: clear with bit0=0, then clear colliding with event
        bus_wr(A_LO, 32'd4, c);
        bus_wr(A_CTRL, 32'h5, k);
        exp_q.push_back(k + 6);
        wait_cyc(k + 6);
        bus_wr(A_STAT, 32'hFFFF_FFFE, c);
        bus_rd(A_STAT, rd); chk(rd == 1, "R7 zero bit ignored", rd, 1);
        wait_cyc(k + 10);
        bus_wr(A_STAT, 32'h1, c);            // captured at edge k+11 = event edge
        bus_rd(A_STAT, rd); chk(rd == 1, "R8 set wins over clear", rd, 1);
        chk(irq == 1'b1, "R8 irq held", irq, 1);
        bus_wr(A_CTRL, 32'h4, c);
        bus_wr(A_STAT, 32'h1, c);
        bus_rd(A_STAT, rd); chk(rd == 0, "R7 clear", rd, 0);
        chk(irq == 1'b0, "R7 irq low", irq, 0);
        bus_wr(A_CTRL, 32'h0, c);

        // R11: tick pause of 10 cycles, load 5
        bus_wr(A_LO, 32'd5, c);
        bus_wr(A_CTRL, 32'h5, k);
        exp_q.push_back(k + 17);
        wait_cyc(k + 2);
        tick_en = 1'b0;
        wait_cyc(k + 12);
        tick_en = 1'b1;
        clear_at(k + 17);
        bus_wr(A_CTRL, 32'h0, c);
        chk(exp_q.size() == 0, "R11 delayed event", exp_q.size(), 0);

        // R6: masked run, flag visible, irq gated
        bus_wr(A_LO, 32'd2, c);
        bus_wr(A_CTRL, 32'h1, k);
        wait_cyc(k + 5);
        bus_wr(A_CTRL, 32'h0, c);
        chk(irq == 1'b0, "R6 masked irq", irq, 0);
        bus_rd(A_STAT, rd); chk(rd == 1, "R6 flag pending", rd, 1);
        exp_q.push_back(cyc + 1);
        bus_wr(A_CTRL, 32'h4, c);
        chk(irq == 1'b1, "R6 unmasked irq", irq, 1);
        bus_wr(A_STAT, 32'h1, c);
        chk(irq == 1'b0, "R6 irq after clear", irq, 0);
        chk(exp_q.size() == 0, "R6 unmask edge", exp_q.size(), 0);

        idle(5);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule